// File: doc/BRIEF.md
# MDIO Management Register Slave

This block sits on a Clause 22 MDIO management bus next to a real Ethernet PHY and answers at its own PHY address as if it were a second PHY. A host that already drives the management bus to set up its PHY can reach the board-control registers without any extra pins or protocol. The registers it can reach are identifier words, a MAC address, several control words and a status word.

The slave runs on a system clock and oversamples MDC and MDIO through synchronizers. It takes a bit on each rising MDC edge it detects. It recognises a frame only after a run of at least `PRE_LEN` ones, a start pattern `01`, a read or write opcode and a matching PHY address. The register file has sixteen 16-bit entries, addressed by the low four bits of a 5-bit register address:

- Two entries are fixed identifiers.
- Six entries are read/write storage whose contents drive output ports:
  - the advertisement-style word
  - two routing-select words
  - the reset/interrupt control word
  - two extended-access words
- One entry is a status word made up of live inputs and inputs captured after reset.
- Three entries return the MAC address, which is supplied on an input port together with its valid flag.

The upper byte of the control word accepts two key values. One key turns on a watchdog enable and the other turns on an extra-function enable.

Top module: `mdio_vphy_regs`

## Requirements
- R1: A read frame is a preamble, start `01`, opcode `10`, the 5-bit PHY address equal to `PHY_ADDR`, a 5-bit register address, a 2-bit turnaround and 16 data bits. The slave returns the addressed register MSB first, one bit per MDC period. A write frame has the same layout with opcode `01`, and the host drives both turnaround bits and the data.
- R2: In a matching read, MDIO is released during the first turnaround bit and driven to 0 during the second. Each data bit changes only after a rising MDC edge. MDIO is released after the rising edge that ends the last data bit.
- R3: A frame whose PHY address is not `PHY_ADDR` changes no register, and MDIO output enable stays low for the whole frame.
- R4: A frame is accepted only after at least `PRE_LEN` consecutive ones (default 32). A frame with a shorter preamble has no effect, and a longer preamble is accepted.
- R5: Register 2 reads `ID_HI` and register 3 reads `ID_LO`. Writes to either have no effect.
- R6: Registers 4, 5, 6, 7, 13 and 14 are read/write. Register 4 resets to `ADV_RST` and the others reset to 0. Each is visible on its own output port one clock after the write frame ends.
- R7: Bits 7..0 of register 7 appear on `reg_ctl[7:0]` as the control lines, in this order from bit 0 upward:
  - interrupt enable 1
  - interrupt enable 2
  - RTC interrupt enable
  - PHY interrupt enable
  - USB reset
  - Ethernet PHY reset
  - MMC reset
  - Ethernet clock enable
- R8: Writing `KEY_WDOG` (0xE5) into bits 15..8 of register 7 sets `wdog_en`, and writing `KEY_EXTRA` (0xA5) sets `extra_en`. Both stay set until reset. Any other upper byte leaves them unchanged.
- R9: Register 8 reads as follows:
  - bits 3..0: `irq_in`
  - bits 6..4: 0
  - bit 7: captured `boot_in[1]`
  - bit 8: `boot_in[0]`
  - bit 9: `boot_in[1]`
  - bit 10: `noseq_in`
  - bit 11: captured `noseq_in`
  - bit 12: `wd_event_in`
  - bit 13: `pg_aux_in`
  - bit 14: `wdog_en | extra_en`
  - bit 15: `mac_valid`
- R10: The captured boot and NOSEQ bits take their values once, shortly after reset is released, and do not follow later changes of the inputs.
- R11: Registers 9, 10 and 11 return `mac_addr[47:32]`, `mac_addr[31:16]` and `mac_addr[15:0]`.
- R12: Registers 0, 1, 12, 15 and register addresses 16..31 read 0, and writes to them have no effect.
- R13: Frames with opcode `00` or `11` change no register and never drive MDIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the host |
| mdio_in | input | 1 | Management data as seen on the bus |
| mdio_out | output | 1 | Management data driven by the slave |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| irq_in | input | 4 | Interrupt lines reported in status |
| boot_in | input | 2 | Boot-mode strap inputs |
| noseq_in | input | 1 | NOSEQ sequencing-mode input |
| wd_event_in | input | 1 | Watchdog event flag |
| pg_aux_in | input | 1 | Auxiliary power-good input |
| mac_addr | input | 48 | MAC address returned by registers 9..11 |
| mac_valid | input | 1 | MAC address valid flag |
| reg_adv | output | 16 | Register 4 contents |
| reg_route_a | output | 16 | Register 5 contents (LED/NOSEQ selects) |
| reg_route_b | output | 16 | Register 6 contents (XIO/clock selects) |
| reg_ctl | output | 16 | Register 7 contents (resets, enables, key byte) |
| reg_mmd_ctl | output | 16 | Register 13 contents |
| reg_mmd_data | output | 16 | Register 14 contents |
| wdog_en | output | 1 | Watchdog enable, set by key |
| extra_en | output | 1 | Extra-function enable, set by key |

## Verification
A rising MDC edge reaches the frame logic `SYNC_STAGES`+1 clocks after the pin moves, and MDIO changes one clock after that. The bench holds each MDC level for 8 clocks and reads the bus just before it raises MDC, well after each slave bit has settled. Register ports and enables are updated one clock after the rising edge that ends a write frame, so the bench checks them several clocks after the frame task returns. Status inputs pass through the same synchronizer depth, so the bench sets them many clocks before the read frame whose snapshot is taken at the first turnaround edge.

// File: rtl/mvp_pkg.sv
package mvp_pkg;
   localparam int REG_W     = 16;
   localparam int ADDR_W    = 5;
   localparam int HDR_BITS  = 12;
   localparam int DATA_BITS = 16;
   localparam int N_REGS    = 16;
   localparam int STAT_W    = 9;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   localparam logic [ADDR_W-1:0] A_ID_HI   = 5'd2;
   localparam logic [ADDR_W-1:0] A_ID_LO   = 5'd3;
   localparam logic [ADDR_W-1:0] A_ADV     = 5'd4;
   localparam logic [ADDR_W-1:0] A_ROUTE_A = 5'd5;
   localparam logic [ADDR_W-1:0] A_ROUTE_B = 5'd6;
   localparam logic [ADDR_W-1:0] A_CTL     = 5'd7;
   localparam logic [ADDR_W-1:0] A_STAT    = 5'd8;
   localparam logic [ADDR_W-1:0] A_MAC_HI  = 5'd9;
   localparam logic [ADDR_W-1:0] A_MAC_MI  = 5'd10;
   localparam logic [ADDR_W-1:0] A_MAC_LO  = 5'd11;
   localparam logic [ADDR_W-1:0] A_MMD_C   = 5'd13;
   localparam logic [ADDR_W-1:0] A_MMD_D   = 5'd14;

   // entries holding writable storage
   localparam logic [N_REGS-1:0] RW_MASK = 16'b0110_0000_1111_0000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_HDR,
      ST_TA,
      ST_DATA
   } mvp_state_e;
endpackage

// File: rtl/mvp_sync.sv
module mvp_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = WIDTH * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mvp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/mvp_frame.sv
module mvp_frame
   import mvp_pkg::*;
#(
   parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd7,
   parameter int                PRE_LEN  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_val,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              wr_stb,
   output logic [REG_W-1:0]  wr_data,
   input  logic [REG_W-1:0]  rd_data,
   output logic              mdio_out,
   output logic              mdio_oe
);
   localparam int PRE_W = $clog2(PRE_LEN + 1);
   localparam int CNT_W = $clog2(DATA_BITS) + 1;
   localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PRE_LEN);
   localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
   localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_BITS - 1);

   mvp_state_e             state;
   logic [PRE_W-1:0]       pre_cnt;
   logic [CNT_W-1:0]       cnt;
   logic [HDR_BITS-1:0]    hdr;
   logic [HDR_BITS-1:0]    hdr_next;
   logic [REG_W-1:0]       rd_shift;
   logic [REG_W-1:0]       wr_shift;
   logic                   do_rd;
   logic                   do_wr;
   logic                   phy_hit;

   assign hdr_next = {hdr[HDR_BITS-2:0], bit_val};
   assign phy_hit  = (hdr_next[2*ADDR_W-1:ADDR_W] == PHY_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pre_cnt  <= '0;
         cnt      <= '0;
         hdr      <= '0;
         rd_shift <= '0;
         wr_shift <= '0;
         do_rd    <= 1'b0;
         do_wr    <= 1'b0;
         acc_addr <= '0;
         wr_stb   <= 1'b0;
         wr_data  <= '0;
         mdio_out <= 1'b0;
         mdio_oe  <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (bit_stb) begin
            unique case (state)
               ST_IDLE: begin
                  if (bit_val) begin
                     if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
                  end else begin
                     if (pre_cnt == PRE_FULL) state <= ST_START;
                     pre_cnt <= '0;
                  end
               end
               ST_START: begin
                  cnt   <= '0;
                  state <= bit_val ? ST_HDR : ST_IDLE;
               end
               ST_HDR: begin
                  hdr <= hdr_next;
                  cnt <= cnt + 1'b1;
                  if (cnt == HDR_LAST) begin
                     state    <= ST_TA;
                     cnt      <= '0;
                     acc_addr <= hdr_next[ADDR_W-1:0];
                     do_rd    <= phy_hit && (hdr_next[HDR_BITS-1 -: 2] == OP_RD);
                     do_wr    <= phy_hit && (hdr_next[HDR_BITS-1 -: 2] == OP_WR);
                  end
               end
               ST_TA: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == '0) begin
                     // end of first turnaround bit: snapshot, drive 0
                     rd_shift <= rd_data;
                     if (do_rd) begin
                        mdio_oe  <= 1'b1;
                        mdio_out <= 1'b0;
                     end
                  end else begin
                     state    <= ST_DATA;
                     cnt      <= '0;
                     mdio_out <= rd_shift[REG_W-1];
                     rd_shift <= {rd_shift[REG_W-2:0], 1'b0};
                  end
               end
               ST_DATA: begin
                  cnt      <= cnt + 1'b1;
                  wr_shift <= {wr_shift[REG_W-2:0], bit_val};
                  if (cnt == DAT_LAST) begin
                     state    <= ST_IDLE;
                     cnt      <= '0;
                     pre_cnt  <= '0;
                     mdio_oe  <= 1'b0;
                     mdio_out <= 1'b0;
                     if (do_wr) begin
                        wr_stb  <= 1'b1;
                        wr_data <= {wr_shift[REG_W-2:0], bit_val};
                     end
                  end else begin
                     mdio_out <= rd_shift[REG_W-1];
                     rd_shift <= {rd_shift[REG_W-2:0], 1'b0};
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mvp_regs.sv
module mvp_regs
   import mvp_pkg::*;
#(
   parameter logic [REG_W-1:0] ID_HI     = 16'h2A5C,
   parameter logic [REG_W-1:0] ID_LO     = 16'h91E0,
   parameter logic [REG_W-1:0] ADV_RST   = 16'h01E1,
   parameter logic [7:0]       KEY_WDOG  = 8'hE5,
   parameter logic [7:0]       KEY_EXTRA = 8'hA5,
   parameter int               CAP_WAIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [STAT_W-1:0] stat_s,
   input  logic [47:0]       mac_addr,
   input  logic              mac_valid,
   output logic [REG_W-1:0]  reg_adv,
   output logic [REG_W-1:0]  reg_route_a,
   output logic [REG_W-1:0]  reg_route_b,
   output logic [REG_W-1:0]  reg_ctl,
   output logic [REG_W-1:0]  reg_mmd_ctl,
   output logic [REG_W-1:0]  reg_mmd_data,
   output logic              wdog_en,
   output logic              extra_en
);
   localparam int IDX_W = $clog2(N_REGS);
   localparam int CAP_W = $clog2(CAP_WAIT + 2);
   localparam logic [CAP_W-1:0] CAP_LAST = CAP_W'(CAP_WAIT);

   // stat_s: {pg, wd_event, noseq, boot[1:0], irq[3:0]}
   logic [3:0]       irq_s;
   logic [1:0]       boot_s;
   logic             noseq_s, wd_s, pg_s;
   logic [REG_W-1:0] rw_q [N_REGS];
   logic [IDX_W-1:0] idx;
   logic             in_file;
   logic [CAP_W-1:0] cap_cnt;
   logic             boot_cap, noseq_cap;
   logic [REG_W-1:0] status;

   assign {pg_s, wd_s, noseq_s, boot_s, irq_s} = stat_s;
   assign idx     = acc_addr[IDX_W-1:0];
   assign in_file = (acc_addr < ADDR_W'(N_REGS));

   function automatic logic [REG_W-1:0] reset_of(input int i);
      return (i == int'(A_ADV)) ? ADV_RST : '0;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_REGS; i++) rw_q[i] <= reset_of(i);
      end else if (wr_stb && in_file && RW_MASK[idx]) begin
         rw_q[idx] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdog_en  <= 1'b0;
         extra_en <= 1'b0;
      end else if (wr_stb && acc_addr == A_CTL) begin
         if (wr_data[15:8] == KEY_WDOG)  wdog_en  <= 1'b1;
         if (wr_data[15:8] == KEY_EXTRA) extra_en <= 1'b1;
      end
   end

   // one-time capture once the synchronizers hold real input values
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_cnt   <= '0;
         boot_cap  <= 1'b0;
         noseq_cap <= 1'b0;
      end else if (cap_cnt != CAP_LAST + 1'b1) begin
         cap_cnt <= cap_cnt + 1'b1;
         if (cap_cnt == CAP_LAST) begin
            boot_cap  <= boot_s[1];
            noseq_cap <= noseq_s;
         end
      end
   end

   assign status = {mac_valid, wdog_en | extra_en, pg_s, wd_s, noseq_cap,
                    noseq_s, boot_s[1], boot_s[0], boot_cap, 3'b000, irq_s};

   always_comb begin
      unique case (acc_addr)
         A_ID_HI:  rd_data = ID_HI;
         A_ID_LO:  rd_data = ID_LO;
         A_STAT:   rd_data = status;
         A_MAC_HI: rd_data = mac_addr[47:32];
         A_MAC_MI: rd_data = mac_addr[31:16];
         A_MAC_LO: rd_data = mac_addr[15:0];
         default:  rd_data = (in_file && RW_MASK[idx]) ? rw_q[idx] : '0;
      endcase
   end

   assign reg_adv      = rw_q[A_ADV[IDX_W-1:0]];
   assign reg_route_a  = rw_q[A_ROUTE_A[IDX_W-1:0]];
   assign reg_route_b  = rw_q[A_ROUTE_B[IDX_W-1:0]];
   assign reg_ctl      = rw_q[A_CTL[IDX_W-1:0]];
   assign reg_mmd_ctl  = rw_q[A_MMD_C[IDX_W-1:0]];
   assign reg_mmd_data = rw_q[A_MMD_D[IDX_W-1:0]];
endmodule

// File: rtl/mdio_vphy_regs.sv
module mdio_vphy_regs
   import mvp_pkg::*;
#(
   parameter logic [ADDR_W-1:0] PHY_ADDR    = 5'd7,
   parameter int                PRE_LEN     = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [REG_W-1:0]  ID_HI       = 16'h2A5C,
   parameter logic [REG_W-1:0]  ID_LO       = 16'h91E0,
   parameter logic [REG_W-1:0]  ADV_RST     = 16'h01E1,
   parameter logic [7:0]        KEY_WDOG    = 8'hE5,
   parameter logic [7:0]        KEY_EXTRA   = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mdc,
   input  logic        mdio_in,
   output logic        mdio_out,
   output logic        mdio_oe,
   input  logic [3:0]  irq_in,
   input  logic [1:0]  boot_in,
   input  logic        noseq_in,
   input  logic        wd_event_in,
   input  logic        pg_aux_in,
   input  logic [47:0] mac_addr,
   input  logic        mac_valid,
   output logic [15:0] reg_adv,
   output logic [15:0] reg_route_a,
   output logic [15:0] reg_route_b,
   output logic [15:0] reg_ctl,
   output logic [15:0] reg_mmd_ctl,
   output logic [15:0] reg_mmd_data,
   output logic        wdog_en,
   output logic        extra_en
);
   generate
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("mdio_vphy_regs: PRE_LEN out of range 1..64");
      end
      if (KEY_WDOG == KEY_EXTRA) begin : g_bad_keys
         $error("mdio_vphy_regs: the two key values must differ");
      end
   endgenerate

   logic              mdc_s, mdio_s, mdc_d, mdc_rise;
   logic [ADDR_W-1:0] acc_addr;
   logic              wr_stb;
   logic [REG_W-1:0]  wr_data;
   logic [REG_W-1:0]  rd_data;
   logic [STAT_W-1:0] stat_s;

   mvp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({mdc, mdio_in}), .q({mdc_s, mdio_s})
   );

   mvp_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_stat_sync (
      .clk(clk), .rst_n(rst_n),
      .d({pg_aux_in, wd_event_in, noseq_in, boot_in, irq_in}),
      .q(stat_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdc_d <= 1'b0;
      else        mdc_d <= mdc_s;
   end
   assign mdc_rise = mdc_s & ~mdc_d;

   mvp_frame #(.PHY_ADDR(PHY_ADDR), .PRE_LEN(PRE_LEN)) u_frame (
      .clk(clk), .rst_n(rst_n), .bit_stb(mdc_rise), .bit_val(mdio_s),
      .acc_addr(acc_addr), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_data(rd_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
   );

   mvp_regs #(
      .ID_HI(ID_HI), .ID_LO(ID_LO), .ADV_RST(ADV_RST),
      .KEY_WDOG(KEY_WDOG), .KEY_EXTRA(KEY_EXTRA), .CAP_WAIT(SYNC_STAGES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .acc_addr(acc_addr),
      .wr_data(wr_data), .rd_data(rd_data), .stat_s(stat_s),
      .mac_addr(mac_addr), .mac_valid(mac_valid),
      .reg_adv(reg_adv), .reg_route_a(reg_route_a), .reg_route_b(reg_route_b),
      .reg_ctl(reg_ctl), .reg_mmd_ctl(reg_mmd_ctl), .reg_mmd_data(reg_mmd_data),
      .wdog_en(wdog_en), .extra_en(extra_en)
   );
endmodule

// File: rtl/mvp_chk.sv
module mvp_chk #(
   parameter logic [7:0] KEY_WDOG  = 8'hE5,
   parameter logic [7:0] KEY_EXTRA = 8'hA5
) (
   input logic        clk,
   input logic        rst_n,
   input logic        mdc_rise,
   input logic        mdio_out,
   input logic        mdio_oe,
   input logic        wr_stb,
   input logic [4:0]  acc_addr,
   input logic [15:0] wr_data,
   input logic [15:0] reg_route_a,
   input logic [15:0] reg_ctl,
   input logic        wdog_en,
   input logic        extra_en
);
   // R2: the first driven turnaround value is 0
   a_r2_ta_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_out);

   // R2: output enable only moves right after a detected MDC rise
   a_r2_oe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe != $past(mdio_oe)) |-> $past(mdc_rise));

   // R6: routing word changes only through a write to its address
   a_r6_route_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_route_a) |-> $past(wr_stb && acc_addr == 5'd5));

   // R7: control word changes only through a write to its address
   a_r7_ctl_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_ctl) |-> $past(wr_stb && acc_addr == 5'd7));

   // R8: enables are sticky
   a_r8_wdog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_en |=> wdog_en);
   a_r8_extra_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      extra_en |=> extra_en);

   // R8: enables rise only on a keyed control write
   a_r8_wdog_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_en) |-> $past(wr_stb && acc_addr == 5'd7 && wr_data[15:8] == KEY_WDOG));
   a_r8_extra_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(extra_en) |-> $past(wr_stb && acc_addr == 5'd7 && wr_data[15:8] == KEY_EXTRA));
endmodule

bind mdio_vphy_regs mvp_chk #(.KEY_WDOG(KEY_WDOG), .KEY_EXTRA(KEY_EXTRA)) u_chk (
   .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdio_out(mdio_out),
   .mdio_oe(mdio_oe), .wr_stb(wr_stb), .acc_addr(acc_addr), .wr_data(wr_data),
   .reg_route_a(reg_route_a), .reg_ctl(reg_ctl), .wdog_en(wdog_en),
   .extra_en(extra_en)
);

// File: tb/mdio_vphy_regs_tb_top.sv
module mdio_vphy_regs_tb_top;
   localparam logic [4:0]  PHY    = 5'd7;
   localparam logic [15:0] IDH    = 16'h2A5C;
   localparam logic [15:0] IDL    = 16'h91E0;
   localparam logic [15:0] ADVR   = 16'h01E1;
   localparam logic [47:0] MAC    = 48'h0A1B_2C3D_4E5F;
   localparam int          HALF   = 8;
   localparam logic [1:0]  OP_RD  = 2'b10;
   localparam logic [1:0]  OP_WR  = 2'b01;

   // vector: {wr, phy[4:0], reg[4:0], data[15:0], exp[15:0]}
   localparam int NV = 26;
   localparam logic [NV-1:0][42:0] VEC = {
      {1'b0, PHY,  5'd2,  16'h0000, IDH},       // R5
      {1'b0, PHY,  5'd3,  16'h0000, IDL},       // R5
      {1'b1, PHY,  5'd2,  16'hFFFF, 16'h0000},  // R5 write ignored
      {1'b0, PHY,  5'd2,  16'h0000, IDH},       // R5
      {1'b0, PHY,  5'd4,  16'h0000, ADVR},      // R6 reset value
      {1'b1, PHY,  5'd4,  16'h1234, 16'h0000},  // R6
      {1'b0, PHY,  5'd4,  16'h0000, 16'h1234},  // R1 R6
      {1'b1, PHY,  5'd5,  16'hA5C3, 16'h0000},  // R6
      {1'b0, PHY,  5'd5,  16'h0000, 16'hA5C3},  // R6
      {1'b1, PHY,  5'd6,  16'h0F1E, 16'h0000},  // R6
      {1'b0, PHY,  5'd6,  16'h0000, 16'h0F1E},  // R6
      {1'b1, PHY,  5'd13, 16'hBEEF, 16'h0000},  // R6
      {1'b0, PHY,  5'd13, 16'h0000, 16'hBEEF},  // R6
      {1'b1, PHY,  5'd14, 16'hC0DE, 16'h0000},  // R6
      {1'b0, PHY,  5'd14, 16'h0000, 16'hC0DE},  // R6
      {1'b0, PHY,  5'd9,  16'h0000, 16'h0A1B},  // R11
      {1'b0, PHY,  5'd10, 16'h0000, 16'h2C3D},  // R11
      {1'b0, PHY,  5'd11, 16'h0000, 16'h4E5F},  // R11
      {1'b0, PHY,  5'd0,  16'h0000, 16'h0000},  // R12
      {1'b0, PHY,  5'd15, 16'h0000, 16'h0000},  // R12
      {1'b1, PHY,  5'd12, 16'h1111, 16'h0000},  // R12
      {1'b0, PHY,  5'd12, 16'h0000, 16'h0000},  // R12
      {1'b0, PHY,  5'd31, 16'h0000, 16'h0000},  // R12
      {1'b1, 5'd3, 5'd4,  16'h5555, 16'h0000},  // R3 other address
      {1'b0, PHY,  5'd4,  16'h0000, 16'h1234},  // R3 unchanged
      {1'b0, PHY,  5'd8,  16'h0000, 16'h958A}   // R9 R10 status
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mdc = 1'b0;
   logic m_oe = 1'b1;
   logic m_drv = 1'b1;
   logic mdio_in, mdio_out, mdio_oe;
   logic [3:0] irq_in = 4'h0;
   logic [1:0] boot_in = 2'b10;
   logic noseq_in = 1'b0, wd_event_in = 1'b0, pg_aux_in = 1'b0;
   logic mac_valid = 1'b1;
   logic [15:0] reg_adv, reg_route_a, reg_route_b, reg_ctl, reg_mmd_ctl, reg_mmd_data;
   logic wdog_en, extra_en;
   int n_chk = 0;
   int n_fail = 0;
   int oe_cnt = 0;

   always #5 clk = ~clk;

   assign mdio_in = mdio_oe ? mdio_out : (m_oe ? m_drv : 1'b1);

   always @(posedge clk) if (mdio_oe) oe_cnt <= oe_cnt + 1;

   mdio_vphy_regs #(.PHY_ADDR(PHY), .ID_HI(IDH), .ID_LO(IDL), .ADV_RST(ADVR)) dut_i (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .irq_in(irq_in),
      .boot_in(boot_in), .noseq_in(noseq_in), .wd_event_in(wd_event_in),
      .pg_aux_in(pg_aux_in), .mac_addr(MAC), .mac_valid(mac_valid),
      .reg_adv(reg_adv), .reg_route_a(reg_route_a), .reg_route_b(reg_route_b),
      .reg_ctl(reg_ctl), .reg_mmd_ctl(reg_mmd_ctl), .reg_mmd_data(reg_mmd_data),
      .wdog_en(wdog_en), .extra_en(extra_en)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic drv, input logic val, output logic b, output logic o);
      m_oe = drv;
      m_drv = val;
      wclk(HALF);
      b = mdio_in;
      o = mdio_oe;
      mdc = 1'b1;
      wclk(HALF);
      mdc = 1'b0;
   endtask

   task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] wd, input int pre, input logic check_ta,
                        output logic [15:0] rd, output int oe_seen);
      logic b, o;
      int start_cnt;
      logic [11:0] hdr;
      start_cnt = oe_cnt;
      hdr = {op, phy, ra};
      rd = '0;
      for (int i = 0; i < pre; i++) send_bit(1'b1, 1'b1, b, o);
      send_bit(1'b1, 1'b0, b, o);
      send_bit(1'b1, 1'b1, b, o);
      for (int i = 11; i >= 0; i--) send_bit(1'b1, hdr[i], b, o);
      if (op == OP_RD) begin
         send_bit(1'b0, 1'b1, b, o);
         if (check_ta) chk("R2 ta1 released", {15'd0, o}, 16'd0);
         send_bit(1'b0, 1'b1, b, o);
         if (check_ta) chk("R2 ta2 driven zero", {14'd0, o, b}, 16'd2);
         for (int i = 15; i >= 0; i--) begin
            send_bit(1'b0, 1'b1, b, o);
            rd[i] = b;
         end
         wclk(6);
         if (check_ta) chk("R2 released after data", {15'd0, mdio_oe}, 16'd0);
      end else begin
         send_bit(1'b1, 1'b1, b, o);
         send_bit(1'b1, 1'b0, b, o);
         for (int i = 15; i >= 0; i--) send_bit(1'b1, wd[i], b, o);
      end
      m_oe = 1'b1;
      m_drv = 1'b1;
      wclk(6);
      oe_seen = oe_cnt - start_cnt;
   endtask

   task automatic rd_reg(input logic [4:0] ra, output logic [15:0] v);
      int s;
      frame(OP_RD, PHY, ra, 16'h0, 32, 1'b1, v, s);
   endtask

   task automatic wr_reg(input logic [4:0] ra, input logic [15:0] v, input int pre);
      logic [15:0] d;
      int s;
      frame(OP_WR, PHY, ra, v, pre, 1'b0, d, s);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      int s;
      wclk(10);
      rst_n = 1'b1;
      wclk(20);
      // reset state R6 R8
      chk("R6 reset oe", {15'd0, mdio_oe}, 16'd0);
      chk("R6 reset adv", reg_adv, ADVR);
      chk("R6 reset ctl", reg_ctl, 16'h0000);
      chk("R8 reset enables", {14'd0, wdog_en, extra_en}, 16'd0);
      // live status inputs; captured bits must keep reset-time values (R10)
      boot_in = 2'b01;
      noseq_in = 1'b1;
      irq_in = 4'b1010;
      wd_event_in = 1'b1;
      pg_aux_in = 1'b0;
      wclk(10);

      for (int k = NV - 1; k >= 0; k--) begin
         logic [42:0] e;
         e = VEC[k];
         if (e[42]) begin
            frame(OP_WR, e[41:37], e[36:32], e[31:16], 32, 1'b0, v, s);
            chk("R3 no drive on write", 16'(s), 16'd0);
         end else begin
            frame(OP_RD, e[41:37], e[36:32], 16'h0, 32, e[41:37] == PHY, v, s);
            chk($sformatf("R1 read reg %0d", e[36:32]), v, e[15:0]);
         end
      end

      // R3 read at other PHY address: bus stays pulled up, no drive
      frame(OP_RD, 5'd3, 5'd2, 16'h0, 32, 1'b0, v, s);
      chk("R3 foreign read data", v, 16'hFFFF);
      chk("R3 foreign read drive", 16'(s), 16'd0);

      // R6 port view
      chk("R6 route_a port", reg_route_a, 16'hA5C3);
      chk("R6 route_b port", reg_route_b, 16'h0F1E);
      chk("R6 mmd ports", reg_mmd_ctl ^ reg_mmd_data, 16'hBEEF ^ 16'hC0DE);

      // R4 short preamble ignored, long accepted
      wr_reg(5'd13, 16'h1111, 31);
      rd_reg(5'd13, v);
      chk("R4 short preamble", v, 16'hBEEF);
      wr_reg(5'd13, 16'h2222, 40);
      rd_reg(5'd13, v);
      chk("R4 long preamble", v, 16'h2222);

      // R13 invalid opcodes
      frame(2'b11, PHY, 5'd14, 16'h7777, 32, 1'b0, v, s);
      chk("R13 op11 no drive", 16'(s), 16'd0);
      frame(2'b00, PHY, 5'd14, 16'h6666, 32, 1'b0, v, s);
      chk("R13 op00 no drive", 16'(s), 16'd0);
      rd_reg(5'd14, v);
      chk("R13 reg unchanged", v, 16'hC0DE);

      // R7 R8 control word and keys
      wr_reg(5'd7, 16'h3300, 32);
      chk("R8 other key", {14'd0, wdog_en, extra_en}, 16'd0);
      wr_reg(5'd7, 16'hE5A6, 32);
      chk("R7 ctl port", reg_ctl, 16'hE5A6);
      chk("R7 eth reset bit5", {15'd0, reg_ctl[5]}, 16'd1);
      chk("R8 wdog key", {14'd0, wdog_en, extra_en}, 16'd2);
      wr_reg(5'd7, 16'h0000, 32);
      chk("R8 wdog sticky", {14'd0, wdog_en, extra_en}, 16'd2);
      wr_reg(5'd7, 16'hA500, 32);
      chk("R8 extra key", {14'd0, wdog_en, extra_en}, 16'd3);
      rd_reg(5'd8, v);
      chk("R9 status with enables", v, 16'hD58A);

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule